// File: doc/BRIEF.md
# Streaming Binary Cross Erosion

This block erodes a one-bit raster image as it streams past. Black is logic 1 and white is logic 0, so the image holds black objects on a white ground. For each pixel, the block looks at a plus-shaped neighbourhood: the pixel itself and the pixels directly above, below, left and right of it. The output pixel is black only when all five of those are black. Anything outside the frame counts as white. As a result, every pixel in the first and last rows and in the first and last columns always comes out white.

Pixels enter one per cycle when `in_valid` is high. `in_sof` marks the top-left pixel. Line ends follow from the `IMG_W` parameter, and frame ends follow from `IMG_H`. The block holds the last two rows plus one pixel in a delay chain, and it taps that chain for the five window values. Those five values are reduced by a tree of four majority cells, each with one input tied low so that it acts as a 2-input AND. The output for a pixel appears one row plus one pixel after that pixel enters. After the last pixel of a frame, the block sends out the final `IMG_W+1` results by itself. The upstream source must stay idle while it does so.

Top module: `erode_cross`

## Requirements
- R1: With black encoded as 1, an output pixel at an interior position is 1 exactly when that position and its north, south, east and west neighbours are all 1 in the input frame.
- R2: Output pixels in row 0, row IMG_H-1, column 0 or column IMG_W-1 are always 0.
- R3: Results leave in raster order. The result for position q is registered at the clock edge that accepts input position q+IMG_W+1, counting positions from 0 in raster order within the frame.
- R4: An accepted pixel with `in_sof` high is position 0 of a new frame. The first IMG_W+1 accepted pixels of a frame produce no output.
- R5: After the pixel at position IMG_W*IMG_H-1 is accepted, the remaining IMG_W+1 results (all 0) follow on consecutive cycles with no further input. `in_valid` must stay low for those cycles.
- R6: `out_sof` is high only with the result for position 0. `out_eol` is high only with results in column IMG_W-1.
- R7: While `rst_n` is low and after its release, `out_valid`, `out_sof` and `out_eol` are low until input arrives.
- R8: The majority cell outputs 1 when at least two of its three inputs are 1. With one input held at 0 it acts as a 2-input AND, and four such cells form the 5-input AND.
- R9: Cycles with `in_valid` low inside a frame neither advance the window nor produce output. A frame sent with gaps gives the same results as one sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_pix | input | 1 | Input pixel, 1 = black |
| in_sof | input | 1 | Input pixel is the first of a frame |
| out_valid | output | 1 | Result present this cycle |
| out_pix | output | 1 | Eroded pixel, 1 = black |
| out_sof | output | 1 | Result is for the top-left position |
| out_eol | output | 1 | Result is for the last column |

## Verification
The following rules are checked on every clock edge:
- The start-of-frame and end-of-line results are white.
- Flush cycles produce white, valid results.
- An idle input cycle or a start-of-frame pixel yields no output on the next edge.
- A majority cell with one input tied low behaves as an AND.

Only the bench scenarios can show the value of each interior result against a model erosion, the exact latency in accepted pixels, and the full per-frame result count. Those scenarios use random frames of several densities, all-black and all-white frames, a single-hole frame, and input with gaps.

// File: rtl/maj3.sv
module maj3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y
);
  assign y = (a & b) | (a & c) | (b & c);

  always_comb begin
    AST_MAJ_CLAMP: assert (a || (y == (b & c))); // R8
  end
endmodule

// File: rtl/erode_cross.sv
module erode_cross #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_pix,
  input  logic in_sof,
  output logic out_valid,
  output logic out_pix,
  output logic out_sof,
  output logic out_eol
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);
  localparam int FW = $clog2(IMG_W + 1);
  localparam int DL = 2 * IMG_W + 1;

  logic [DL-1:0] hist;
  logic [CW-1:0] col_q, eff_c, ctr_c;
  logic [RW-1:0] row_q, eff_r, ctr_r;
  logic          fl_on;
  logic [FW-1:0] fl_cnt;

  assign eff_c = in_sof ? '0 : col_q;
  assign eff_r = in_sof ? '0 : row_q;

  logic last_c, last_r, primed, interior;
  assign last_c = (eff_c == CW'(IMG_W - 1));
  assign last_r = (eff_r == RW'(IMG_H - 1));
  assign primed = (eff_r > RW'(1)) || ((eff_r == RW'(1)) && (eff_c != '0));
  assign ctr_c  = (eff_c != '0) ? eff_c - CW'(1) : CW'(IMG_W - 1);
  assign ctr_r  = (eff_c != '0) ? eff_r - RW'(1) : eff_r - RW'(2);
  assign interior = (ctr_r != '0) && (ctr_r != RW'(IMG_H - 1)) &&
                    (ctr_c != '0) && (ctr_c != CW'(IMG_W - 1));

  logic t_n, t_s, t_e, t_w, t_c;
  assign t_s = hist[0];
  assign t_e = hist[IMG_W-1];
  assign t_c = hist[IMG_W];
  assign t_w = hist[IMG_W+1];
  assign t_n = hist[2*IMG_W];

  logic and_ns, and_ew, and_4, and_5;
  maj3 u_and_ns (.a(t_n),    .b(t_s),    .c(1'b0), .y(and_ns));
  maj3 u_and_ew (.a(t_e),    .b(t_w),    .c(1'b0), .y(and_ew));
  maj3 u_and_4  (.a(and_ns), .b(and_ew), .c(1'b0), .y(and_4));
  maj3 u_and_5  (.a(and_4),  .b(t_c),    .c(1'b0), .y(and_5));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist      <= '0;
      col_q     <= '0;
      row_q     <= '0;
      fl_on     <= 1'b0;
      fl_cnt    <= '0;
      out_valid <= 1'b0;
      out_pix   <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_pix   <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      if (fl_on) begin
        out_valid <= 1'b1;
        out_eol   <= (fl_cnt == '0) || (fl_cnt == FW'(IMG_W));
        fl_cnt    <= fl_cnt + FW'(1);
        if (fl_cnt == FW'(IMG_W)) fl_on <= 1'b0;
      end else if (in_valid) begin
        hist <= {hist[DL-2:0], in_pix};
        if (last_c) begin
          col_q <= '0;
          row_q <= last_r ? '0 : eff_r + RW'(1);
        end else begin
          col_q <= eff_c + CW'(1);
          row_q <= eff_r;
        end
        if (last_c && last_r) begin
          fl_on  <= 1'b1;
          fl_cnt <= '0;
        end
        if (primed) begin
          out_valid <= 1'b1;
          out_pix   <= interior ? and_5 : 1'b0;
          out_sof   <= (ctr_r == '0) && (ctr_c == '0);
          out_eol   <= (ctr_c == CW'(IMG_W - 1));
        end
      end
    end
  end

  AST_SOF_CORNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && !out_pix)); // R6
  AST_EOL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> !out_pix); // R2
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fl_on |=> (out_valid && !out_pix && !out_sof)); // R5
  AST_NO_OUT_AT_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !fl_on) |=> !out_valid); // R4
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !fl_on) |=> !out_valid); // R9
endmodule

// File: tb/erode_cross_tb.sv
`timescale 1ns/1ps
module erode_cross_tb;
  localparam int W = 8;
  localparam int H = 6;
  localparam int N = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_pix = 1'b0, in_sof = 1'b0;
  logic out_valid, out_pix, out_sof, out_eol;
  logic ma = 1'b0, mb = 1'b0, mc = 1'b0, my;

  int n_tests = 0;
  int n_fail  = 0;

  bit img [N];
  bit ref_img [N];
  int mon_idx = 0;
  int frame_outs = 0;
  int acc_cnt = 0;

  always #2.5 clk = ~clk;

  erode_cross #(.IMG_W(W), .IMG_H(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .in_sof(in_sof),
    .out_valid(out_valid), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol));

  maj3 u_maj (.a(ma), .b(mb), .c(mc), .y(my));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit px(input int r, input int c);
    if (r < 0 || r >= H || c < 0 || c >= W) return 1'b0;
    return img[r*W+c];
  endfunction

  function automatic void model();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        bit inner = (r > 0) && (r < H-1) && (c > 0) && (c < W-1);
        ref_img[r*W+c] = inner && px(r,c) && px(r-1,c) && px(r+1,c) && px(r,c-1) && px(r,c+1);
      end
  endfunction

  always @(posedge clk)
    if (rst_n && in_valid) acc_cnt = in_sof ? 1 : acc_cnt + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int idx;
      idx = out_sof ? 0 : mon_idx;
      if (idx < N) begin
        check(out_pix == ref_img[idx], (idx/W == 0 || idx/W == H-1 || idx%W == 0 || idx%W == W-1) ? "R2" : "R1",
              out_pix, ref_img[idx]);
        check(out_eol == (idx%W == W-1), "R6 eol", out_eol, idx%W == W-1);
        check(out_sof == (idx == 0), "R6 sof", out_sof, idx == 0);
        if (idx < N-W-1) check(acc_cnt == idx+W+2, "R3 latency", acc_cnt, idx+W+2);
        else             check(acc_cnt == N, "R5 flush", acc_cnt, N);
      end else check(1'b0, "R5 extra output", idx, N-1);
      mon_idx = idx + 1;
      frame_outs++;
    end
  end

  task automatic send_frame(input bit gaps);
    model();
    frame_outs = 0;
    for (int p = 0; p < N; p++) begin
      if (gaps) while ($urandom_range(2) == 0) begin
        in_valid = 1'b0; in_sof = 1'b0; in_pix = $urandom_range(1);
        @(posedge clk); #1;
      end
      in_valid = 1'b1; in_pix = img[p]; in_sof = (p == 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_pix = 1'b0;
    repeat (W + 4) @(posedge clk);
    #1;
    check(frame_outs == N, "R5 count", frame_outs, N);
  endtask

  task automatic fill(input int dens);
    for (int p = 0; p < N; p++) img[p] = ($urandom_range(99) < dens);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin
      {ma, mb, mc} = 3'(k);
      #1;
      check(my == ((ma + mb + mc) >= 2), "R8 majority", my, (ma + mb + mc) >= 2);
    end
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !out_sof && !out_eol, "R7 reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(!out_valid && !out_sof && !out_eol, "R7 idle", out_valid, 0);

    for (int p = 0; p < N; p++) img[p] = 1'b0;
    send_frame(1'b0);
    for (int p = 0; p < N; p++) img[p] = 1'b1;
    send_frame(1'b0);
    img[2*W+3] = 1'b0;
    send_frame(1'b1);
    for (int f = 0; f < 6; f++) begin
      fill((f % 2 == 0) ? 80 : 50);
      send_frame(f >= 3);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule